// File: doc/BRIEF.md
# Block-Write Configuration Slave for a Clock Generator

This block is a two-wire serial slave that loads the configuration registers of a clock-generation device. It runs from a fast system clock and oversamples the serial clock and data lines. It accepts one kind of transaction, a block write, and it acknowledges each accepted byte by pulling the data line low. It has a fixed device address. The host must send a command byte and a count byte before the payload. The slave acknowledges both bytes but does not act on their values. Payload bytes always fill the register file in order, starting at byte 0. No starting offset can be chosen.

The stored bytes drive the device controls directly. One register byte holds a per-output disable mask, and a disabled clock output is driven low rather than left floating. One bit of byte 0 enables spread-spectrum clocking. Bytes pass to the registers at the pace of the serial bus, and the slave cannot hold the bus off. For that reason the block has no valid/ready handshake, and all of its outputs are plain levels.

Top module: `cfg_smb_slave`

## Requirements
- R1: The address byte 0xD2 (7-bit address 0x69 followed by a write bit of 0, sent MSB first) is acknowledged: `sda_oe_o` is high during the high phase of the ninth SCL pulse.
- R2: Any other address byte, including 0xD3 (the read form), is not acknowledged. The slave acknowledges nothing else and changes no register until the next start condition.
- R3: The two bytes after the address are acknowledged whatever their values. Neither byte affects which register receives the payload.
- R4: Payload byte k of a transaction is stored in register byte k, which appears on `cfg_o[8k+7:8k]`, for k from 0 to NREG-1.
- R5: When a stop condition follows a complete byte, every payload byte already received keeps its new value and the other registers keep their old values. A byte that a stop or a start condition interrupts is discarded.
- R6: A repeated start resets the payload pointer, so the next transaction writes again from byte 0.
- R7: Payload bytes beyond NREG are acknowledged and discarded, and the pointer saturates at NREG.
- R8: After the asynchronous reset, every register byte is 0x00, `sda_oe_o` is low and `spread_en_o` is low.
- R9: `clk_o[i]` equals `clk_src_i[i]` when bit i of register byte 1 is 0. It is held low when that bit is 1.
- R10: `spread_en_o` equals bit 0 of register byte 0.
- R11: `sda_oe_o` changes only while SCL is low. It is never high during a data-bit clock pulse, and it is released before the next bit after each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | High means the pad pulls the data line low |
| clk_src_i | input | NCLK | Clock outputs before gating |
| clk_o | output | NCLK | Gated clock outputs, held low when disabled |
| spread_en_o | output | 1 | Spread-spectrum enable |
| cfg_o | output | NREG*8 | Register file contents, byte k at bits 8k+7:8k |

## Verification
The hardest cases to reach from the ports are a stop or a repeated start that arrives part-way through a payload byte or after only some bytes. Those cases test whether the pointer and the half-shifted byte are handled correctly. The stimulus drives the bus bit by bit, so it can end a transfer after four bits of a byte. It also issues a repeated start after two payload bytes. Each case is set up so that a stale register value would differ from the expected one. A longer transfer that runs past the register depth covers pointer saturation. Acknowledge sampling in the ninth clock of every byte covers the address filter.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;
  localparam logic [7:0] DEV_WR_ADDR = 8'hD2;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_BITS,
    RX_ACK,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/cfg_smb_line_sync.sv
module cfg_smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_pipe;
  logic [DEPTH-1:0] sda_pipe;
  logic             scl_p;
  logic             sda_p;

  // idle bus is high, so reset the pipes high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign scl_p = scl_pipe[SYNC_STAGES];
  assign sda_p = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_smb_byte_rx.sv
module cfg_smb_byte_rx
  import cfg_smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  rx_state_e  st;
  phase_e     ph;
  phase_e     ph_next;
  logic [3:0] bit_cnt;
  logic [7:0] shift_q;
  logic       byte_ok;

  assign byte_ok = (ph != PH_ADDR) || (shift_q == DEV_WR_ADDR);
  assign wr_data = shift_q;

  always_comb begin
    case (ph)
      PH_ADDR: ph_next = PH_CMD;
      PH_CMD:  ph_next = PH_CNT;
      default: ph_next = PH_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      ph      <= PH_ADDR;
      bit_cnt <= '0;
      shift_q <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st      <= RX_BITS;
        ph      <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st     <= RX_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          RX_BITS: begin
            if (scl_rise && bit_cnt != BITS_PER_BYTE) begin
              shift_q <= {shift_q[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
              if (byte_ok) begin
                sda_oe <= 1'b1;
                st     <= RX_ACK;
                wr_en  <= (ph == PH_DATA);
                ph     <= ph_next;
              end else begin
                st <= RX_SKIP;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              st      <= RX_BITS;
              bit_cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_smb_regfile.sv
module cfg_smb_regfile #(
  parameter int         NREG    = 8,
  parameter logic [7:0] RST_VAL = 8'h00,
  localparam int        PTR_W   = $clog2(NREG + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  output logic [PTR_W-1:0]           ptr,
  output logic [NREG-1:0][7:0]       regs
);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (wr_en && ptr != PTR_MAX) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= RST_VAL;
      end else if (wr_en && !clr && ptr == PTR_W'(i)) begin
        regs[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cfg_smb_clk_gate.sv
module cfg_smb_clk_gate #(
  parameter int NCLK = 8
) (
  input  logic [NCLK-1:0] clk_src,
  input  logic [NCLK-1:0] dis_mask,
  output logic [NCLK-1:0] clk_out
);
  for (genvar i = 0; i < NCLK; i++) begin : g_out
    assign clk_out[i] = clk_src[i] & ~dis_mask[i];
  end
endmodule

// File: rtl/cfg_smb_slave.sv
module cfg_smb_slave #(
  parameter int         NREG     = 8,
  parameter int         NCLK     = 8,
  parameter int         DIS_BYTE = 1,
  parameter int         SS_BYTE  = 0,
  parameter int         SS_BIT   = 0,
  parameter logic [7:0] RST_VAL  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NCLK-1:0]   clk_src_i,
  output logic [NCLK-1:0]   clk_o,
  output logic              spread_en_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int PTR_W = $clog2(NREG + 1);

  logic                 scl_s;
  logic                 sda_s;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_det;
  logic                 stop_det;
  logic                 wr_en;
  logic [7:0]           wr_data;
  logic [PTR_W-1:0]     ptr;
  logic [NREG-1:0][7:0] regs;

  cfg_smb_line_sync #(.SYNC_STAGES(2)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfg_smb_byte_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  cfg_smb_regfile #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_det),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ptr     (ptr),
    .regs    (regs)
  );

  cfg_smb_clk_gate #(.NCLK(NCLK)) u_gate (
    .clk_src  (clk_src_i),
    .dis_mask (regs[DIS_BYTE][NCLK-1:0]),
    .clk_out  (clk_o)
  );

  assign spread_en_o = regs[SS_BYTE][SS_BIT];
  assign cfg_o       = regs;
endmodule

// File: rtl/cfg_smb_slave_chk.sv
module cfg_smb_slave_chk #(
  parameter int NREG  = 8,
  parameter int PTR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_det,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [PTR_W-1:0]  ptr,
  input logic [NREG*8-1:0] cfg
);
  function automatic logic [7:0] pick(input logic [NREG*8-1:0] v, input logic [PTR_W-1:0] i);
    return v[int'(i)*8 +: 8];
  endfunction

  // R4
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(ptr) < NREG) |=> pick(cfg, $past(ptr)) == $past(wr_data));

  // R5
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

  // R6
  restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> ptr == '0);

  // R7
  ptr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= NREG);

  // R11
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11
  oe_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);
endmodule

bind cfg_smb_slave cfg_smb_slave_chk #(.NREG(NREG), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe_o),
  .start_det (start_det),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ptr       (ptr),
  .cfg       (cfg_o)
);

// File: tb/cfg_smb_slave_tb.sv
`timescale 1ns/1ps
module cfg_smb_slave_tb;
  localparam int NREG = 8;
  localparam int NCLK = 8;
  localparam int H    = 10;

  typedef logic [7:0] bq_t[$];
  typedef struct {
    int         idx;
    logic [7:0] val;
    string      tag;
  } sb_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scl = 1'b1;
  logic              host_sda = 1'b1;
  logic [NCLK-1:0]   clk_src = 8'h55;
  logic              sda_oe;
  logic [NCLK-1:0]   clk_o;
  logic              spread_en;
  logic [NREG*8-1:0] cfg;
  wire               sda_line = host_sda & ~sda_oe;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] model [NREG];
  sb_t        sb_q[$];
  bit         oe_in_data;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;
  always #7 clk_src = ~clk_src;

  cfg_smb_slave #(.NREG(NREG), .NCLK(NCLK)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .clk_src_i   (clk_src),
    .clk_o       (clk_o),
    .spread_en_o (spread_en),
    .cfg_o       (cfg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued register expectations against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        sb_t it;
        it = sb_q.pop_front();
        chk(cfg[it.idx*8 +: 8] == it.val, it.tag, cfg[it.idx*8 +: 8], it.val);
      end
    end
  end

  task automatic push_image(input string tag);
    wt(20);
    for (int i = 0; i < NREG; i++) sb_q.push_back('{i, model[i], tag});
    wait (sb_q.size() == 0);
    wt(1);
  endtask

  task automatic do_start();
    if (!scl) begin
      host_sda = 1'b1; wt(H/2);
      scl = 1'b1; wt(H/2);
    end
    host_sda = 1'b0; wt(H/2);
    scl = 1'b0; wt(H/2);
  endtask

  task automatic do_stop();
    host_sda = 1'b0; wt(H/2);
    scl = 1'b1; wt(H/2);
    host_sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; wt(H/2);
    scl = 1'b1; wt(H/2);
    if (sda_oe) oe_in_data = 1'b1;
    wt(H/2);
    scl = 1'b0; wt(H/2);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    oe_in_data = 1'b0;
    for (int b = 7; b >= 0; b--) send_bit(v[b]);
    host_sda = 1'b1; wt(H/2);
    scl = 1'b1; wt(H/2);
    acked = !sda_line;
    wt(H/2);
    scl = 1'b0; wt(H/2);
    // R11: released before next bit, never held during data bits
    chk(!oe_in_data && !sda_oe, "R11", {oe_in_data, sda_oe}, 0);
  endtask

  task automatic blk_write(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                           input bq_t d, input bit exp_ack, input string tag);
    bit a;
    bit all_ok = 1'b1;
    do_start();
    send_byte(addr, a);
    chk(a == exp_ack, exp_ack ? "R1 address ack" : "R2 address nack", a, exp_ack);
    send_byte(cmd, a); all_ok &= (a == exp_ack);
    send_byte(cnt, a); all_ok &= (a == exp_ack);
    chk(all_ok, exp_ack ? "R3 header acks" : "R2 header nacks", all_ok, 1);
    all_ok = 1'b1;
    foreach (d[i]) begin
      send_byte(d[i], a); all_ok &= (a == exp_ack);
    end
    chk(all_ok, exp_ack ? "R7 payload acks" : "R2 payload nacks", all_ok, 1);
    do_stop();
    if (exp_ack) foreach (d[i]) if (i < NREG) model[i] = d[i];
    push_image(tag);
  endtask

  task automatic run_all();
    bit a;
    bit ok;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wt(4);
    rst_n = 1'b1;
    wt(4);
    // R8
    chk(cfg == '0, "R8 regs", cfg, 0);
    chk(!sda_oe && !spread_en, "R8 oe/spread", {sda_oe, spread_en}, 0);
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin wt(1); ok &= (clk_o == clk_src); end
    chk(ok, "R9 enabled outputs follow source", clk_o, clk_src);

    blk_write(8'hD2, 8'h00, 8'h03, '{8'hA1, 8'hB2, 8'hC3}, 1'b1, "R4 sequential");
    blk_write(8'hA4, 8'h00, 8'h02, '{8'h55, 8'h66}, 1'b0, "R2 foreign address");
    blk_write(8'hD3, 8'h00, 8'h01, '{8'h77}, 1'b0, "R2 read address");
    blk_write(8'hD2, 8'h7E, 8'h20, '{8'h11}, 1'b1, "R3 header ignored");

    // R5: two complete bytes, then stop in the middle of the third
    do_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
    send_byte(8'h44, a); send_byte(8'h55, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    do_stop();
    model[0] = 8'h44; model[1] = 8'h55;
    push_image("R5 early stop");

    // R6: repeated start after two payload bytes
    do_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_byte(8'h21, a); send_byte(8'h22, a);
    do_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h31, a);
    chk(a, "R6 ack after restart", a, 1);
    do_stop();
    model[0] = 8'h31; model[1] = 8'h22;
    push_image("R6 repeated start");

    blk_write(8'hD2, 8'h00, 8'h0A,
              '{8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87, 8'h88, 8'h89},
              1'b1, "R7 overflow discarded");

    blk_write(8'hD2, 8'h00, 8'h02, '{8'h01, 8'h05}, 1'b1, "R4 control bytes");
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      wt(1);
      ok &= (clk_o == (clk_src & ~8'h05));
    end
    chk(ok, "R9 disabled outputs held low", clk_o, clk_src & ~8'h05);
    chk(spread_en == 1'b1, "R10 spread enable", spread_en, 1);

    blk_write(8'hD2, 8'h00, 8'h01, '{8'hFE}, 1'b1, "R4 byte0 rewrite");
    chk(spread_en == 1'b0, "R10 spread disable", spread_en, 0);
  endtask

  initial begin
    fork
      begin run_all(); done = 1'b1; end
      begin repeat (150000) @(posedge clk); end
    join_any
    disable fork;
    if (!done) chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule